// File: doc/BRIEF.md
# Scratchpad Operand Address Generator

This block turns the memory-operand fields of a decoded virtual-machine instruction into scratchpad byte addresses. It handles two operands. The source operand names a register and a 32-bit read mask. The result operand names a register and a 32-bit write mask, which is the same field as the instruction's 32-bit immediate. Each operand also carries a 3-bit location code. The code selects one of three targets: the whole scratchpad, a small window at the start of the scratchpad, or a plain register.

The block holds the eight 64-bit integer registers that the addresses are built from. Forming the source address has a side effect. The named register is XORed with the sign-extended read mask, and the new value is written back. Forming the result address only reads its register. An instruction is captured on a clock edge where `in_valid` is high. Its addresses, the register values used, and the memory flags appear during the next cycle, with `out_valid` high. The write-back of the source register takes place on the clock edge that ends that cycle, so the next instruction already sees the updated value.

Top module: `spad_addr_gen`

## Requirements
- R1: After reset, all eight registers read as zero and `out_valid` is low.
- R2: On each accepted instruction, source register `a_reg` becomes its old value XOR the 32-bit `a_mask` sign-extended to 64 bits (bit 31 copied into bits 63:32). `a_value` shows this updated value. Repeated instructions on the same register accumulate.
- R3: The source byte address is the low index bits of the updated register value, masked to the selected window, then multiplied by 8 (three zero bits appended).
- R4: Location code 0 selects the full window (FULL_ENTRIES eight-byte entries, index masked by FULL_ENTRIES-1). Codes 1, 2 and 3 select the small window (SMALL_ENTRIES entries, index masked by SMALL_ENTRIES-1; 2048 entries by default, i.e. 16 KiB). Codes 4 to 7 select a register, and the matching `*_is_mem` output is then low. This decode applies to both operands.
- R5: The result byte address is ((`c_mask` XOR bits 31:0 of the result register), masked to the window) times 8. The result register is never written, and `c_value` shows its value.
- R6: When `c_reg` equals `a_reg`, the result address and `c_value` use the value already updated by R2 in the same instruction.
- R7: All eight 3-bit register indices and all eight location codes are valid.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In a cycle with `in_valid` low, the instruction inputs have no effect on any register.
- R9: The source register update of R2 also happens when the source location code selects a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction fields below are valid this cycle |
| a_reg | input | 3 | Source operand register index |
| a_loc | input | 3 | Source operand location code |
| a_mask | input | 32 | Source read mask |
| c_reg | input | 3 | Result operand register index |
| c_loc | input | 3 | Result operand location code |
| c_mask | input | 32 | Result write mask (the 32-bit immediate) |
| out_valid | output | 1 | Outputs below belong to the last accepted instruction |
| a_is_mem | output | 1 | Source is a scratchpad access |
| a_addr | output | ADDR_W (18) | Source byte address, 8-byte aligned |
| a_value | output | 64 | Updated source register value |
| c_is_mem | output | 1 | Result is a scratchpad access |
| c_addr | output | ADDR_W (18) | Result byte address, 8-byte aligned |
| c_value | output | 64 | Result register value used for the address |

## Verification
All address and value outputs of an instruction are due in the cycle after the edge that captured it, and `out_valid` marks that cycle. The effect of the write-back shows up in the instruction that follows. The driver applies inputs on falling edges, and the monitor compares whatever is flagged valid on the next falling edge, popping expected results in issue order. This keeps each check exactly one cycle behind its stimulus. The absence of an update during idle cycles, and the fact that the result register stays untouched, are observed later through `a_value` and `c_value` of follow-up instructions that use a zero mask.

// File: rtl/spad_pkg.sv
package spad_pkg;

    localparam int REG_COUNT = 8;
    localparam int REG_W     = 64;
    localparam int MASK_W    = 32;
    localparam int SEL_W     = 3;
    localparam int ALIGN_W   = 3;

    typedef enum logic [1:0] {
        WIN_FULL  = 2'd0,
        WIN_SMALL = 2'd1,
        WIN_REG   = 2'd2
    } window_e;

    typedef struct packed {
        logic [SEL_W-1:0]  a_reg;
        logic [SEL_W-1:0]  a_loc;
        logic [MASK_W-1:0] a_mask;
        logic [SEL_W-1:0]  c_reg;
        logic [SEL_W-1:0]  c_loc;
        logic [MASK_W-1:0] c_mask;
    } operand_instr_t;

    function automatic window_e loc_to_window(input logic [SEL_W-1:0] loc);
        if (loc == '0)
            return WIN_FULL;
        else if (!loc[SEL_W-1])
            return WIN_SMALL;
        else
            return WIN_REG;
    endfunction

    function automatic logic [REG_W-1:0] widen_mask(input logic [MASK_W-1:0] m);
        return {{(REG_W-MASK_W){m[MASK_W-1]}}, m};
    endfunction

endpackage

// File: rtl/spad_regfile.sv
module spad_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 64,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd0_idx,
    output logic [DW-1:0] rd0_data,
    input  logic [IW-1:0] rd1_idx,
    output logic [DW-1:0] rd1_data,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] store [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (we && wr_idx == IW'(g))
                store[g] <= wr_data;
        end
    end

    assign rd0_data = store[rd0_idx];
    assign rd1_data = store[rd1_idx];
endmodule

// File: rtl/spad_window_addr.sv
module spad_window_addr
    import spad_pkg::*;
#(
    parameter int FULL_ENTRIES  = 32768,
    parameter int SMALL_ENTRIES = 2048,
    parameter int ADDR_W        = $clog2(FULL_ENTRIES) + ALIGN_W
) (
    input  logic [SEL_W-1:0]  loc,
    input  logic [MASK_W-1:0] index_src,
    output logic              is_mem,
    output logic [ADDR_W-1:0] byte_addr
);
    localparam logic [MASK_W-1:0] FULL_MASK  = MASK_W'(FULL_ENTRIES - 1);
    localparam logic [MASK_W-1:0] SMALL_MASK = MASK_W'(SMALL_ENTRIES - 1);

    window_e           win;
    logic [MASK_W-1:0] idx;

    always_comb begin
        win = loc_to_window(loc);
        unique case (win)
            WIN_FULL:  idx = index_src & FULL_MASK;
            WIN_SMALL: idx = index_src & SMALL_MASK;
            default:   idx = '0;
        endcase
        is_mem    = (win != WIN_REG);
        byte_addr = ADDR_W'({idx, {ALIGN_W{1'b0}}});
    end
endmodule

// File: rtl/spad_addr_gen.sv
module spad_addr_gen
    import spad_pkg::*;
#(
    parameter int FULL_ENTRIES  = 32768,
    parameter int SMALL_ENTRIES = 2048,
    localparam int IDX_W        = $clog2(FULL_ENTRIES),
    localparam int ADDR_W       = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        a_reg,
    input  logic [2:0]        a_loc,
    input  logic [31:0]       a_mask,
    input  logic [2:0]        c_reg,
    input  logic [2:0]        c_loc,
    input  logic [31:0]       c_mask,
    output logic              out_valid,
    output logic              a_is_mem,
    output logic [ADDR_W-1:0] a_addr,
    output logic [63:0]       a_value,
    output logic              c_is_mem,
    output logic [ADDR_W-1:0] c_addr,
    output logic [63:0]       c_value
);
    operand_instr_t    instr_q;
    logic              valid_q;
    logic [REG_W-1:0]  src_cur;
    logic [REG_W-1:0]  dst_cur;
    logic [REG_W-1:0]  src_upd;
    logic [REG_W-1:0]  dst_eff;
    logic [MASK_W-1:0] dst_index;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            instr_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid)
                instr_q <= '{a_reg: a_reg, a_loc: a_loc, a_mask: a_mask,
                             c_reg: c_reg, c_loc: c_loc, c_mask: c_mask};
        end
    end

    spad_regfile #(
        .NREG (REG_COUNT),
        .DW   (REG_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rd0_idx  (instr_q.a_reg),
        .rd0_data (src_cur),
        .rd1_idx  (instr_q.c_reg),
        .rd1_data (dst_cur),
        .we       (valid_q),
        .wr_idx   (instr_q.a_reg),
        .wr_data  (src_upd)
    );

    always_comb begin
        src_upd   = src_cur ^ widen_mask(instr_q.a_mask);
        dst_eff   = (instr_q.c_reg == instr_q.a_reg) ? src_upd : dst_cur;
        dst_index = dst_eff[MASK_W-1:0] ^ instr_q.c_mask;
    end

    spad_window_addr #(
        .FULL_ENTRIES  (FULL_ENTRIES),
        .SMALL_ENTRIES (SMALL_ENTRIES),
        .ADDR_W        (ADDR_W)
    ) u_src_addr (
        .loc       (instr_q.a_loc),
        .index_src (src_upd[MASK_W-1:0]),
        .is_mem    (a_is_mem),
        .byte_addr (a_addr)
    );

    spad_window_addr #(
        .FULL_ENTRIES  (FULL_ENTRIES),
        .SMALL_ENTRIES (SMALL_ENTRIES),
        .ADDR_W        (ADDR_W)
    ) u_dst_addr (
        .loc       (instr_q.c_loc),
        .index_src (dst_index),
        .is_mem    (c_is_mem),
        .byte_addr (c_addr)
    );

    assign out_valid = valid_q;
    assign a_value   = src_upd;
    assign c_value   = dst_eff;
endmodule

// File: rtl/spad_addr_gen_chk.sv
module spad_addr_gen_chk #(
    parameter int SMALL_ENTRIES = 2048,
    parameter int ADDR_W        = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        a_loc,
    input logic [2:0]        c_loc,
    input logic              out_valid,
    input logic              a_is_mem,
    input logic              c_is_mem,
    input logic [ADDR_W-1:0] c_addr
);
    assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_reg_mode_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_loc[2]) |=> !a_is_mem);

    assert_full_mode_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && c_loc == 3'd0) |=> c_is_mem);

    assert_small_window_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && c_loc != 3'd0 && !c_loc[2])
            |=> (c_is_mem && c_addr < ADDR_W'(SMALL_ENTRIES * 8)));
endmodule

bind spad_addr_gen spad_addr_gen_chk #(
    .SMALL_ENTRIES (SMALL_ENTRIES),
    .ADDR_W        (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_loc     (a_loc),
    .c_loc     (c_loc),
    .out_valid (out_valid),
    .a_is_mem  (a_is_mem),
    .c_is_mem  (c_is_mem),
    .c_addr    (c_addr)
);

// File: tb/test_spad_addr_gen.sv
module test_spad_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int FULL_E     = 32768;
    localparam int SMALL_E    = 2048;
    localparam int AW         = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [2:0]    a_reg, a_loc, c_reg, c_loc;
    logic [31:0]   a_mask, c_mask;
    logic          out_valid, a_is_mem, c_is_mem;
    logic [AW-1:0] a_addr, c_addr;
    logic [63:0]   a_value, c_value;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        bit            a_mem;
        logic [AW-1:0] a_addr;
        logic [63:0]   a_val;
        bit            c_mem;
        logic [AW-1:0] c_addr;
        logic [63:0]   c_val;
        string         tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] model [8];

    spad_addr_gen i_spad_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_reg(a_reg), .a_loc(a_loc), .a_mask(a_mask),
        .c_reg(c_reg), .c_loc(c_loc), .c_mask(c_mask),
        .out_valid(out_valid), .a_is_mem(a_is_mem), .a_addr(a_addr),
        .a_value(a_value), .c_is_mem(c_is_mem), .c_addr(c_addr),
        .c_value(c_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit win_mem(logic [2:0] loc);
        return !loc[2];
    endfunction

    function automatic logic [AW-1:0] win_addr(logic [2:0] loc, logic [31:0] v);
        logic [31:0] m;
        m = (loc == 3'd0) ? 32'(FULL_E - 1) : 32'(SMALL_E - 1);
        return AW'((v & m) << 3);
    endfunction

    task automatic issue(logic [2:0] ar, logic [2:0] al, logic [31:0] am,
                         logic [2:0] cr, logic [2:0] cl, logic [31:0] cm,
                         string tag);
        exp_t e;
        model[ar] = model[ar] ^ {{32{am[31]}}, am};
        e.a_mem  = win_mem(al);
        e.a_addr = win_addr(al, model[ar][31:0]);
        e.a_val  = model[ar];
        e.c_mem  = win_mem(cl);
        e.c_addr = win_addr(cl, model[cr][31:0] ^ cm);
        e.c_val  = model[cr];
        e.tag    = tag;
        sb.push_back(e);
        in_valid = 1'b1;
        a_reg = ar; a_loc = al; a_mask = am;
        c_reg = cr; c_loc = cl; c_mask = cm;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops the expected item in the cycle the design flags a result.
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            if (sb.size() == 0) begin
                check("R8 unexpected out_valid", 64'(out_valid), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " a_is_mem"}, 64'(a_is_mem), 64'(e.a_mem));
                if (e.a_mem) check({e.tag, " a_addr"}, 64'(a_addr), 64'(e.a_addr));
                check({e.tag, " a_value"}, a_value, e.a_val);
                check({e.tag, " c_is_mem"}, 64'(c_is_mem), 64'(e.c_mem));
                if (e.c_mem) check({e.tag, " c_addr"}, 64'(c_addr), 64'(e.c_addr));
                check({e.tag, " c_value"}, c_value, e.c_val);
            end
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=timeout expected=finish");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 8; i++) model[i] = '0;
        rst = 1'b1; in_valid = 1'b0;
        a_reg = '0; a_loc = '0; a_mask = '0; c_reg = '0; c_loc = '0; c_mask = '0;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
        // R1: every register reads zero
        for (int r = 0; r < 8; r++) issue(3'(r), 3'd4, 32'd0, 3'(7 - r), 3'd5, 32'd0, "R1 zero regs");
        // R2 R3 R4: accumulation, full and small windows
        issue(3'd3, 3'd0, 32'h0000_1234, 3'd1, 3'd4, 32'd0, "R2 R3 first update full");
        issue(3'd3, 3'd1, 32'h0000_1000, 3'd1, 3'd4, 32'd0, "R2 R3 accumulate small");
        // R2: negative mask sign-extends
        issue(3'd5, 3'd2, 32'h8000_0010, 3'd0, 3'd6, 32'd0, "R2 sign extension");
        issue(3'd4, 3'd3, 32'hFFFF_FFFF, 3'd0, 3'd7, 32'd0, "R4 small window code 3");
        // R5: write address from mask and dest, full and small windows
        issue(3'd0, 3'd6, 32'd0, 3'd5, 3'd0, 32'h0000_7FF0, "R5 write full");
        issue(3'd0, 3'd6, 32'd0, 3'd5, 3'd1, 32'h0000_7FF0, "R5 write small");
        issue(3'd5, 3'd4, 32'd0, 3'd6, 3'd4, 32'd0, "R5 dest unchanged");
        // R6: same register for both operands
        issue(3'd2, 3'd0, 32'h0001_2345, 3'd2, 3'd0, 32'h0000_00FF, "R6 forwarding");
        // R9: update while source selects a register
        issue(3'd6, 3'd7, 32'hDEAD_BEEF, 3'd6, 3'd5, 32'd0, "R9 reg mode update");
        issue(3'd6, 3'd0, 32'd0, 3'd1, 3'd2, 32'h0000_0123, "R9 value kept");
        // R8: idle garbage must not change state
        a_reg = 3'd6; a_mask = 32'hFFFF_FFFF; c_reg = 3'd6; c_mask = 32'h1;
        repeat (3) @(negedge clk);
        check("R8 idle out_valid", 64'(out_valid), 64'd0);
        issue(3'd6, 3'd0, 32'd0, 3'd6, 3'd0, 32'd0, "R8 idle no effect");
        // R7: sweep all indices and codes back to back
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 64; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            issue(3'(i), 3'(i >> 3), lfsr, 3'(lfsr[7:5]), 3'(i + 3), ~lfsr, "R7 sweep");
        end
        repeat (3) @(negedge clk);
        check("R8 queue drained", 64'(sb.size()), 64'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule